// File: doc/BRIEF.md
# Lockable GPIO Port Register File

This block is an eight-pin general-purpose I/O port controlled through a small register-write bus. Software sets a direction per pin and a value to drive. It reads back a data view that merges its own stored values on output pins with the live pad levels on input pins. Any pin can also be handed to a peripheral, which then supplies both the output value and the output enable for that pin.

The peripheral hand-over bits are protected against stray writes. A write to the peripheral-select register changes only the bits enabled in a commit mask. The commit mask itself can be rewritten only after a 32-bit key has been written to a lock register. Every write to the mask closes the lock again, so each mask change needs a fresh unlock. Register accesses complete in one cycle. Writes take effect at the clock edge and read data is combinational from the address.

Top module: `gpio_lk_port`

## Requirements
- R1: After reset the data, direction and peripheral-select registers read 0, the lock register reads 1 (locked), the commit mask reads 0xFF, and every pin output enable is 0.
- R2: A read of the data register (offset 0x00) returns, per bit, the stored data value where the direction bit is 1 and the live pin input where the direction bit is 0.
- R3: For a pin whose peripheral-select bit is 0, the pin output equals the stored data bit and the pin output enable equals the direction bit.
- R4: For a pin whose peripheral-select bit is 1, the pin output and output enable equal the peripheral's output and enable bits for that pin.
- R5: A write to the peripheral-select register (offset 0x08) updates only the bits whose commit-mask bit is 1. All other bits keep their old values.
- R6: A write of exactly 0x4C4F434B to the lock register (offset 0x0C) unlocks it, and it then reads 0. A write of any other value locks it, and it then reads 1.
- R7: A write to the commit mask (offset 0x10) while locked leaves the mask unchanged.
- R8: A write to the commit mask while unlocked loads bits [7:0] into the mask, and the lock register reads 1 afterwards.
- R9: Data and direction are written at offsets 0x00 and 0x04 from bits [7:0]. A write to any unmapped offset changes no register. A read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_in | input | 8 | Sampled pad levels |
| periph_out | input | 8 | Peripheral-driven output values |
| periph_oe | input | 8 | Peripheral-driven output enables |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |

## Verification
Two functions can meet in one cycle: a write that changes the peripheral-select bits, and the peripheral inputs and software registers that the pin multiplexer is selecting between. The bench provokes this by changing periph_out, periph_oe and pin_in at random in the same cycle as writes that go through a partial commit mask. In the cycle after the edge it checks each pad output bit against a model. Committed bits must follow the peripheral, and masked bits must stay with the software registers.

// File: rtl/gpio_lk_pkg.sv
package gpio_lk_pkg;

    localparam logic [7:0] OFS_DATA  = 8'h00;
    localparam logic [7:0] OFS_DIR   = 8'h04;
    localparam logic [7:0] OFS_AFSEL = 8'h08;
    localparam logic [7:0] OFS_LOCK  = 8'h0C;
    localparam logic [7:0] OFS_CR    = 8'h10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_DIR,
        SEL_AFSEL,
        SEL_LOCK,
        SEL_CR
    } reg_sel_e;

    typedef struct packed {
        logic out;
        logic oe;
    } pin_drv_t;

    function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
        case (ofs)
            OFS_DATA:  return SEL_DATA;
            OFS_DIR:   return SEL_DIR;
            OFS_AFSEL: return SEL_AFSEL;
            OFS_LOCK:  return SEL_LOCK;
            OFS_CR:    return SEL_CR;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_lk_swregs.sv
module gpio_lk_swregs #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_data,
    input  logic         wr_dir,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] data_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] data_view
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dir_q  <= '0;
        end else begin
            if (wr_data) data_q <= wdata;
            if (wr_dir)  dir_q  <= wdata;
        end
    end

    always_comb begin
        data_view = (data_q & dir_q) | (pin_in & ~dir_q);
    end

    p_dir_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !wr_dir |=> $stable(dir_q));

    p_data_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !wr_data |=> $stable(data_q));

endmodule

// File: rtl/gpio_lk_guard.sv
module gpio_lk_guard #(
    parameter int unsigned     W          = 8,
    parameter int unsigned     BUS_W      = 32,
    parameter logic [BUS_W-1:0] UNLOCK_KEY = 32'h4C4F434B
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_afsel,
    input  logic             wr_lock,
    input  logic             wr_cr,
    input  logic [BUS_W-1:0] wdata,
    output logic [W-1:0]     afsel_q,
    output logic [W-1:0]     cr_q,
    output logic             locked_q
);

    logic [W-1:0] afsel_next;

    always_comb begin
        afsel_next = (afsel_q & ~cr_q) | (wdata[W-1:0] & cr_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            afsel_q  <= '0;
            cr_q     <= '1;
            locked_q <= 1'b1;
        end else begin
            if (wr_afsel) afsel_q <= afsel_next;
            if (wr_lock) begin
                locked_q <= (wdata != UNLOCK_KEY);
            end else if (wr_cr) begin
                if (!locked_q) cr_q <= wdata[W-1:0];
                locked_q <= 1'b1;
            end
        end
    end

    p_reset_locked_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (locked_q && afsel_q == '0));

    p_afsel_masked_r5: assert property (@(posedge clk) disable iff (rst)
        wr_afsel |=> (((afsel_q ^ $past(afsel_q)) & ~$past(cr_q)) == '0));

    p_key_unlock_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_lock && wdata == UNLOCK_KEY) |=> !locked_q);

    p_cr_locked_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_cr && locked_q) |=> $stable(cr_q));

    p_relock_r8: assert property (@(posedge clk) disable iff (rst)
        wr_cr |=> locked_q);

endmodule

// File: rtl/gpio_lk_pinmux.sv
module gpio_lk_pinmux
    import gpio_lk_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] sel_periph,
    input  logic [W-1:0] sw_out,
    input  logic [W-1:0] sw_oe,
    input  logic [W-1:0] periph_out,
    input  logic [W-1:0] periph_oe,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        pin_drv_t sw_drv;
        pin_drv_t pe_drv;
        pin_drv_t drv;
        always_comb begin
            sw_drv     = '{out: sw_out[i], oe: sw_oe[i]};
            pe_drv     = '{out: periph_out[i], oe: periph_oe[i]};
            drv        = sel_periph[i] ? pe_drv : sw_drv;
            pin_out[i] = drv.out;
            pin_oe[i]  = drv.oe;
        end
    end

endmodule

// File: rtl/gpio_lk_port.sv
module gpio_lk_port
    import gpio_lk_pkg::*;
#(
    parameter int unsigned      PINS       = 8,
    parameter int unsigned      ADDR_W     = 5,
    parameter int unsigned      BUS_W      = 32,
    parameter logic [BUS_W-1:0] UNLOCK_KEY = 32'h4C4F434B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    input  logic [PINS-1:0]   periph_out,
    input  logic [PINS-1:0]   periph_oe,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe
);

    localparam int unsigned PAD_W = BUS_W - PINS;

    reg_sel_e      sel;
    logic [PINS-1:0] data_q, dir_q, data_view, afsel_q, cr_q;
    logic          locked_q;

    always_comb begin
        sel = decode_ofs(8'(bus_addr));
    end

    gpio_lk_swregs #(.W(PINS)) u_swregs (
        .clk       (clk),
        .rst       (rst),
        .wr_data   (bus_wr && sel == SEL_DATA),
        .wr_dir    (bus_wr && sel == SEL_DIR),
        .wdata     (bus_wdata[PINS-1:0]),
        .pin_in    (pin_in),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .data_view (data_view)
    );

    gpio_lk_guard #(.W(PINS), .BUS_W(BUS_W), .UNLOCK_KEY(UNLOCK_KEY)) u_guard (
        .clk      (clk),
        .rst      (rst),
        .wr_afsel (bus_wr && sel == SEL_AFSEL),
        .wr_lock  (bus_wr && sel == SEL_LOCK),
        .wr_cr    (bus_wr && sel == SEL_CR),
        .wdata    (bus_wdata),
        .afsel_q  (afsel_q),
        .cr_q     (cr_q),
        .locked_q (locked_q)
    );

    gpio_lk_pinmux #(.W(PINS)) u_pinmux (
        .sel_periph (afsel_q),
        .sw_out     (data_q),
        .sw_oe      (dir_q),
        .periph_out (periph_out),
        .periph_oe  (periph_oe),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe)
    );

    always_comb begin
        case (sel)
            SEL_DATA:  bus_rdata = {{PAD_W{1'b0}}, data_view};
            SEL_DIR:   bus_rdata = {{PAD_W{1'b0}}, dir_q};
            SEL_AFSEL: bus_rdata = {{PAD_W{1'b0}}, afsel_q};
            SEL_LOCK:  bus_rdata = {{(BUS_W-1){1'b0}}, locked_q};
            SEL_CR:    bus_rdata = {{PAD_W{1'b0}}, cr_q};
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: tb/gpio_lk_port_tb.sv
`timescale 1ns/100ps
module gpio_lk_port_tb_top;

    localparam logic [31:0] KEY = 32'h4C4F434B;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pin_in = '0, periph_out = '0, periph_oe = '0;
    logic [7:0]  pin_out, pin_oe;

    int nvec = 0;
    int nfail = 0;
    bit finished = 0;

    logic [7:0] m_data, m_dir, m_afsel, m_cr;
    logic       m_locked;

    gpio_lk_port dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .periph_out(periph_out), .periph_oe(periph_oe),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        case (a)
            5'h00:   return {24'h0, (m_data & m_dir) | (pin_in & ~m_dir)};
            5'h04:   return {24'h0, m_dir};
            5'h08:   return {24'h0, m_afsel};
            5'h0C:   return {31'h0, m_locked};
            5'h10:   return {24'h0, m_cr};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [7:0] exp_out();
        return (m_afsel & periph_out) | (~m_afsel & m_data);
    endfunction

    function automatic logic [7:0] exp_oe();
        return (m_afsel & periph_oe) | (~m_afsel & m_dir);
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] expv);
        nvec++;
        if (got !== expv) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", req, got, expv);
        end
    endtask

    task automatic rd_check(input logic [4:0] a, input string req);
        bus_addr = a;
        #0.2;
        check(req, bus_rdata, exp_read(a));
    endtask

    task automatic check_pins();
        check("R3/R4 pin_out", {24'h0, pin_out}, {24'h0, exp_out()});
        check("R3/R4 pin_oe", {24'h0, pin_oe}, {24'h0, exp_oe()});
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        case (a)
            5'h00: m_data = d[7:0];
            5'h04: m_dir = d[7:0];
            5'h08: m_afsel = (m_afsel & ~m_cr) | (d[7:0] & m_cr);
            5'h0C: m_locked = (d != KEY);
            5'h10: begin
                if (!m_locked) m_cr = d[7:0];
                m_locked = 1'b1;
            end
            default: ;
        endcase
    endtask

    task automatic check_all();
        rd_check(5'h00, "R2 data");
        rd_check(5'h04, "R9 dir");
        rd_check(5'h08, "R5 afsel");
        rd_check(5'h0C, "R6 lock");
        rd_check(5'h10, "R8 cr");
        check_pins();
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1597));
        m_data = '0; m_dir = '0; m_afsel = '0; m_cr = 8'hFF; m_locked = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        pin_in = 8'hA5;
        rd_check(5'h00, "R1 data");
        rd_check(5'h04, "R1 dir");
        rd_check(5'h08, "R1 afsel");
        rd_check(5'h0C, "R1 lock");
        rd_check(5'h10, "R1 cr");
        check("R1 pin_oe", {24'h0, pin_oe}, 32'h0);

        // R2 mixed direction readback, R3 software drive
        wr(5'h00, 32'h0000_00F0);
        wr(5'h04, 32'h0000_003C);
        pin_in = 8'h0F;
        rd_check(5'h00, "R2 mixed");
        check_pins();

        // R7 write to mask while locked ignored, R8 relock
        wr(5'h10, 32'h0000_000F);
        rd_check(5'h10, "R7 cr unchanged");
        // R6 wrong key keeps locked, key unlocks
        wr(5'h0C, KEY ^ 32'h1);
        rd_check(5'h0C, "R6 wrong key");
        wr(5'h0C, KEY);
        rd_check(5'h0C, "R6 key unlock");
        wr(5'h10, 32'hFFFF_FF0F);
        rd_check(5'h10, "R8 cr loaded");
        rd_check(5'h0C, "R8 relocked");
        wr(5'h10, 32'h0000_00FF);
        rd_check(5'h10, "R7 after relock");

        // R5 masked commit with R4 peripheral mux
        periph_out = 8'h5A; periph_oe = 8'hC3;
        wr(5'h08, 32'h0000_00FF);
        rd_check(5'h08, "R5 masked afsel");
        check_pins();
        // R6 unlock then lock by other value
        wr(5'h0C, KEY);
        wr(5'h0C, 32'h0);
        rd_check(5'h0C, "R6 relock by other value");
        // R9 unmapped offsets
        wr(5'h14, 32'hFFFF_FFFF);
        wr(5'h1C, 32'hFFFF_FFFF);
        rd_check(5'h14, "R9 unmapped read");
        check_all();

        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [4:0] a;
            logic [31:0] d;
            case ($urandom_range(0, 6))
                0: a = 5'h00; 1: a = 5'h04; 2: a = 5'h08; 3: a = 5'h0C;
                4: a = 5'h10; 5: a = 5'h14; default: a = 5'(4 * $urandom_range(0, 7) + $urandom_range(0, 3));
            endcase
            d = $urandom();
            if (a == 5'h0C && $urandom_range(0, 1) == 1) d = KEY;
            pin_in = 8'($urandom()); periph_out = 8'($urandom()); periph_oe = 8'($urandom());
            wr(a, d);
            check_all();
            rd_check(a, "R9 random addr");
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule